// File: doc/BRIEF.md
# Store Retirement Buffer for a Write-Through Cache

This block sits between a write-through cache and main memory. The cache hands it each store as an address and data pair. The buffer keeps the pair in a small queue and lets the processor continue at once, without waiting for memory. A drain engine then retires the queued stores to memory one at a time, using a request/acknowledge handshake. Memory may take any number of cycles to acknowledge.

When stores arrive faster than memory can absorb them and the queue fills, the block raises a stall toward the processor. A new store may target an address that is still waiting in the queue. In that case the store is held off: the older entry drains first, and only then is the new value taken in. Memory therefore always ends up holding the newest value for every address. An empty flag tells surrounding logic when every accepted store has reached memory.

The drain engine is a two-state machine:
- `DR_IDLE` means no request is outstanding. It moves to `DR_BUSY` when the queue is non-empty.
- `DR_BUSY` drives the memory request for the oldest entry. On an acknowledge it stays in `DR_BUSY` if another entry is waiting, or if one is arriving in that same cycle. Otherwise it returns to `DR_IDLE`.

Top module: `wbuf_top`

## Requirements
- R1: After reset the buffer is empty: `buf_empty` is 1, `mem_req` is 0, and `st_stall` is 0 while `st_valid` is low.
- R2: A store is accepted in a cycle where `st_valid` is 1 and `st_stall` is 0. Its data reaches `mem_data` unchanged when that entry is acknowledged.
- R3: Accepted stores are written to memory in strict arrival order, each with its full address on `mem_addr`.
- R4: The depth is a parameter of at least 4 (default 4). While memory does not acknowledge, DEPTH stores to distinct addresses are accepted without any stall.
- R5: `st_stall` is 1 in the same cycle when `st_valid` is 1 and DEPTH entries are pending. `st_stall` is 0 whenever `st_valid` is 0.
- R6: `st_stall` is 1 while `st_valid` is 1 and `st_addr` equals the address of any pending entry. The new value is accepted only after the older entry has been acknowledged, so memory receives the old value first and then the new one.
- R7: Only one memory write is outstanding at a time. Once `mem_req` rises, it stays high with `mem_addr` and `mem_data` stable until the cycle in which `mem_ack` is 1. An entry leaves the buffer only in that cycle.
- R8: `buf_empty` is 1 exactly when no accepted store remains unwritten. `mem_req` is 0 whenever `buf_empty` is 1.
- R9: Any acknowledge latency works, including `mem_ack` in the first cycle of a request. Every accepted store is written exactly once.
- R10: A store presented while stalled and then withdrawn is never enqueued and never reaches memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | A store is presented this cycle |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_stall | output | 1 | Store not taken this cycle (full, or address already pending) |
| mem_req | output | 1 | Memory write request for the oldest entry |
| mem_addr | output | AW | Address of the write being requested |
| mem_data | output | DW | Data of the write being requested |
| mem_ack | input | 1 | Memory has completed the requested write |
| buf_empty | output | 1 | No stores pending |

## Verification
The bench sweeps four acknowledge latencies (0, 1, 2 and 6) over store streams with distinct addresses, alternating addresses, pseudo-random addresses and gapped traffic. It models the queue arithmetically and predicts `st_stall` and every memory write in every cycle.

The same-address case is the sharpest corner. A design that enqueued the new value alongside the old one would leave the order intact, but would stall in the wrong cycles. A design that overwrote the pending entry would lose a memory write. Both are caught, by the stall prediction and by the per-run write count.

Zero-latency acknowledge catches an engine that drops a back-to-back entry or pops twice. The full-buffer case catches an off-by-one on the full condition. A withdrawn stalled store catches a design that latches stores regardless of stall.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    // Drain engine state: no write outstanding, or one write requested.
    typedef enum logic [0:0] {
        DR_IDLE = 1'b0,
        DR_BUSY = 1'b1
    } drain_state_t;

    // Advance a circular slot pointer with an explicit wrap.
    function automatic int unsigned next_slot(input int unsigned cur, input int unsigned depth);
        return (cur == depth - 1) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/wbuf_store.sv
module wbuf_store
    import wbuf_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  logic [AW-1:0]         push_addr,
    input  logic [DW-1:0]         push_data,
    input  logic                  pop,
    output logic [AW-1:0]         head_addr,
    output logic [DW-1:0]         head_data,
    output logic                  full,
    output logic                  empty,
    output logic                  more_than_one,
    output logic [DEPTH*AW-1:0]   slot_addr_flat,
    output logic [DEPTH-1:0]      slot_valid
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [DEPTH-1:0] valid_q;
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= PW'(next_slot(int'(wr_ptr), DEPTH));
            end
            if (pop) begin
                rd_ptr <= PW'(next_slot(int'(rd_ptr), DEPTH));
            end
            if (push && !pop) begin
                count <= count + 1'b1;
            end else if (pop && !push) begin
                count <= count - 1'b1;
            end
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q[i]  <= '0;
                data_q[i]  <= '0;
                valid_q[i] <= 1'b0;
            end else begin
                if (push && (wr_ptr == PW'(i))) begin
                    addr_q[i]  <= push_addr;
                    data_q[i]  <= push_data;
                    valid_q[i] <= 1'b1;
                end else if (pop && (rd_ptr == PW'(i))) begin
                    valid_q[i] <= 1'b0;
                end
            end
        end
        assign slot_addr_flat[i*AW +: AW] = addr_q[i];
    end

    assign slot_valid    = valid_q;
    assign head_addr     = addr_q[rd_ptr];
    assign head_data     = data_q[rd_ptr];
    assign full          = (count == CNT_FULL);
    assign empty         = (count == '0);
    assign more_than_one = (count > CW'(1));

    // R5: the stall logic upstream must never let a store into a full queue.
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R7: an entry is removed only when one is actually pending.
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R2: occupancy moves only through accepted stores or acknowledged writes.
    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(count));

endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
    parameter int AW    = 32,
    parameter int DEPTH = 4
) (
    input  logic [AW-1:0]       probe_addr,
    input  logic [DEPTH*AW-1:0] slot_addr_flat,
    input  logic [DEPTH-1:0]    slot_valid,
    output logic                hit
);

    logic [DEPTH-1:0] slot_hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign slot_hit[i] = slot_valid[i] && (slot_addr_flat[i*AW +: AW] == probe_addr);
    end

    assign hit = |slot_hit;

endmodule

// File: rtl/wbuf_drain.sv
module wbuf_drain
    import wbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic empty,
    input  logic more_than_one,
    input  logic push,
    input  logic mem_ack,
    output logic mem_req,
    output logic pop
);

    drain_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DR_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            DR_IDLE: begin
                if (!empty) begin
                    state_nx = DR_BUSY;
                end
            end
            DR_BUSY: begin
                if (mem_ack) begin
                    state_nx = (more_than_one || push) ? DR_BUSY : DR_IDLE;
                end
            end
            default: state_nx = DR_IDLE;
        endcase
    end

    always_comb begin
        mem_req = 1'b0;
        pop     = 1'b0;
        unique case (state)
            DR_IDLE: begin
                mem_req = 1'b0;
            end
            DR_BUSY: begin
                mem_req = 1'b1;
                pop     = mem_ack;
            end
            default: begin
                mem_req = 1'b0;
            end
        endcase
    end

    // R7: a request, once raised, is held until memory acknowledges it.
    p_hold_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);

endmodule

// File: rtl/wbuf_top.sv
module wbuf_top #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    output logic          st_stall,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    input  logic          mem_ack,
    output logic          buf_empty
);

    logic                push, pop, full, empty, more_than_one, hit;
    logic [DEPTH*AW-1:0] slot_addr_flat;
    logic [DEPTH-1:0]    slot_valid;

    wbuf_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .push           (push),
        .push_addr      (st_addr),
        .push_data      (st_data),
        .pop            (pop),
        .head_addr      (mem_addr),
        .head_data      (mem_data),
        .full           (full),
        .empty          (empty),
        .more_than_one  (more_than_one),
        .slot_addr_flat (slot_addr_flat),
        .slot_valid     (slot_valid)
    );

    wbuf_match #(.AW(AW), .DEPTH(DEPTH)) u_match (
        .probe_addr     (st_addr),
        .slot_addr_flat (slot_addr_flat),
        .slot_valid     (slot_valid),
        .hit            (hit)
    );

    wbuf_drain u_drain (
        .clk           (clk),
        .rst_n         (rst_n),
        .empty         (empty),
        .more_than_one (more_than_one),
        .push          (push),
        .mem_ack       (mem_ack),
        .mem_req       (mem_req),
        .pop           (pop)
    );

    // Hold off a store while the queue is full or an older copy of its
    // address still waits; the older copy drains first.
    assign st_stall  = st_valid && (full || hit);
    assign push      = st_valid && !st_stall;
    assign buf_empty = empty;

    // R7: the presented write does not change while memory is working on it.
    p_req_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_data)));

    // R8: nothing is requested from memory when nothing is pending.
    p_empty_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty |-> !mem_req);

endmodule

// File: tb/test_wbuf_top.sv
module test_wbuf_top;

    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          st_stall;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic          mem_ack = 1'b0;
    logic          buf_empty;

    wbuf_top #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_wbuf_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_valid  (st_valid),
        .st_addr   (st_addr),
        .st_data   (st_data),
        .st_stall  (st_stall),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .mem_ack   (mem_ack),
        .buf_empty (buf_empty)
    );

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;

    // Bench model of the pending queue.
    logic [AW-1:0] qa [DEPTH];
    logic [DW-1:0] qd [DEPTH];
    int qn = 0;
    int lat = 0;
    int wcnt = 0;
    int n_acc = 0;
    int n_wr = 0;
    bit hold_chk = 0;
    logic [AW-1:0] h_a;
    logic [DW-1:0] h_d;
    logic [DW-1:0] data_ctr = 8'd1;
    logic [15:0] lcg = 16'h1d3;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
    endtask

    task automatic step(input logic v, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic acc);
        bit exp_full, exp_hit, exp_stall, ack;
        string tag;
        @(negedge clk);
        st_valid = v;
        st_addr  = a;
        st_data  = d;
        ack = mem_req && (wcnt >= lat);
        mem_ack = ack;
        #1;
        if (hold_chk) begin
            chk(mem_req == 1'b1, "R7", int'(mem_req), 1);
            chk(mem_addr == h_a && mem_data == h_d, "R7", int'(mem_addr), int'(h_a));
        end
        chk(buf_empty == (qn == 0), "R8", int'(buf_empty), int'(qn == 0));
        if (qn == 0) chk(mem_req == 1'b0, "R8", int'(mem_req), 0);
        exp_full = (qn == DEPTH);
        exp_hit = 0;
        for (int i = 0; i < qn; i++) if (qa[i] == a) exp_hit = 1;
        exp_stall = v && (exp_full || exp_hit);
        tag = exp_full ? "R5" : (exp_hit ? "R6" : "R4");
        chk(st_stall == exp_stall, tag, int'(st_stall), int'(exp_stall));
        if (mem_req && ack) begin
            chk(qn > 0, "R9", qn, 1);
            if (qn > 0) begin
                chk(mem_addr == qa[0], "R3", int'(mem_addr), int'(qa[0]));
                chk(mem_data == qd[0], "R2", int'(mem_data), int'(qd[0]));
                for (int i = 0; i < DEPTH - 1; i++) begin
                    qa[i] = qa[i+1];
                    qd[i] = qd[i+1];
                end
                qn--;
            end
            n_wr++;
            wcnt = 0;
        end else if (mem_req) begin
            wcnt++;
        end
        hold_chk = mem_req && !ack;
        h_a = mem_addr;
        h_d = mem_data;
        acc = v && !exp_stall;
        if (acc) begin
            qa[qn] = a;
            qd[qn] = d;
            qn++;
            n_acc++;
        end
    endtask

    task automatic send(input logic [AW-1:0] a);
        logic acc;
        acc = 1'b0;
        for (int k = 0; k < 100 && !acc; k++) begin
            step(1'b1, a, data_ctr, acc);
        end
        data_ctr = data_ctr + 8'd1;
    endtask

    task automatic idle(input int n);
        logic acc;
        for (int k = 0; k < n; k++) step(1'b0, '0, '0, acc);
    endtask

    task automatic drain_all;
        logic acc;
        for (int k = 0; k < 300 && !(qn == 0 && buf_empty); k++) step(1'b0, '0, '0, acc);
        idle(2);
    endtask

    initial begin
        #(4 * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic acc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(buf_empty == 1'b1, "R1", int'(buf_empty), 1);
        chk(mem_req == 1'b0, "R1", int'(mem_req), 0);
        chk(st_stall == 1'b0, "R1", int'(st_stall), 0);

        for (int li = 0; li < 4; li++) begin
            lat = (li == 3) ? 6 : li;
            for (int p = 0; p < 4; p++) begin
                n_acc = 0;
                n_wr  = 0;
                for (int i = 0; i < 24; i++) begin
                    logic [AW-1:0] a;
                    lcg = lcg * 16'd25173 + 16'd13849;
                    unique case (p)
                        0: a = AW'(i);
                        1: a = AW'(i % 2);
                        2: a = lcg[11:8];
                        default: a = AW'(i % 5);
                    endcase
                    send(a);
                    if (p == 3 && (i % 3 == 0)) idle(i % 4);
                end
                drain_all();
                // R9: every accepted store written exactly once at this latency
                chk(n_wr == n_acc, "R9", n_wr, n_acc);
            end
        end

        // R4 / R5 / R10: fill with acknowledges held off, then withdraw a stalled store.
        lat = 40;
        n_acc = 0;
        n_wr  = 0;
        for (int i = 0; i < DEPTH; i++) send(AW'(8 + i));
        for (int k = 0; k < 5; k++) step(1'b1, 4'h3, 8'hee, acc);
        step(1'b0, '0, '0, acc);
        drain_all();
        chk(n_acc == DEPTH, "R10", n_acc, DEPTH);
        chk(n_wr == DEPTH, "R10", n_wr, DEPTH);

        summary();
        $finish;
    end

endmodule